// File: doc/BRIEF.md
# Nonmaskable Interrupt Source Aggregator

This block gathers five independent error sources into a single nonmaskable interrupt request for a host processor. The five sources are a vector fetch error, a clock failure, an external request pin, a watchdog reset of a companion core, and a stuck line on an inter-core bus. Each source latches a sticky flag. Software writes 1 to a bit of a clear register to remove that flag. An enable register selects which latched flags drive the interrupt. The enables have mixed reset values: four sources are active from reset and the bus source starts off. The vector fetch source can never be turned off.

The clock-failure condition is also forwarded on a separate output towards the companion processor. The external pin is asynchronous, so it passes through a synchronizer and a rising-edge detector before it can set its flag. A bus-stuck event latches its flag even while its enable is low, so software can see it and enable it afterwards.

Top module: `nmi_src_aggregator`

## Requirements
- R1: After reset, `flags_o` is 0, `enables_o` is 5'b01111, and `nmi_o` and `peer_clkfail_o` are 0.
- R2: The flag bits are assigned as follows: bit 0 vector fetch error, bit 1 clock failure, bit 2 external pin, bit 3 companion watchdog reset, bit 4 bus stuck. A non-pin source that is high at a clock edge sets its flag at that edge.
- R3: A flag stays set until a write to address 1 (the clear register) carries a 1 in its bit. Bits written as 0 leave their flags unchanged.
- R4: If a source is active in the same cycle as the clear of its flag, the flag stays set.
- R5: A write to address 0 loads bits 4..1 of `enables_o` from the write data. Bit 0 always reads 1, whatever is written.
- R6: The bus-stuck flag latches while its enable is 0 and does not raise `nmi_o`. Enabling it later raises `nmi_o` while the flag is still set.
- R7: The bus-stuck condition is `bus_int_stuck_i` OR `bus_rdy_stuck_i`.
- R8: The pin input passes through two synchronizing flops and a rising-edge detector. The flag sets three clock edges after the pin rises. A pin held high does not set the flag again after it is cleared; only a new rising edge does.
- R9: `nmi_o` is registered. It equals the OR of (flag AND enable) over all sources as of the previous edge, so it stays high until every enabled flag is cleared.
- R10: `peer_clkfail_o` is registered and equals the clock-failure flag AND its enable as of the previous edge.
- R11: Writes to addresses 2 and 3 change neither enables nor flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vfetch_err_i | input | 1 | Vector fetch error event |
| clkfail_i | input | 1 | Clock failure event |
| pin_nmi_i | input | 1 | Asynchronous external request, active high |
| peer_wdrst_i | input | 1 | Companion core watchdog reset event |
| bus_int_stuck_i | input | 1 | Bus interrupt line stuck |
| bus_rdy_stuck_i | input | 1 | Bus ready line stuck |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | 5 | Write data, one bit per source |
| flags_o | output | 5 | Latched flags |
| enables_o | output | 5 | Current enables |
| nmi_o | output | 1 | Nonmaskable interrupt request |
| peer_clkfail_o | output | 1 | Clock-failure request to the companion processor |

## Verification
The bench builds the block with its default parameters: a two-bit address, a two-stage pin synchronizer, and the enable register at address 0 and the clear register at address 1. With a two-bit address, both unmapped addresses can be reached, so their writes can be shown to have no effect. The two-stage synchronizer gives the exact three-edge pin latency that the bench samples against. The default reset and writable masks make the bus source start disabled and the vector fetch enable fixed at 1, so the mixed-default and undisableable cases can both be exercised.

// File: rtl/nmi_agg_pkg.sv
package nmi_agg_pkg;
  localparam int NSRC = 5;

  localparam int SRC_VFETCH  = 0;
  localparam int SRC_CLKFAIL = 1;
  localparam int SRC_PIN     = 2;
  localparam int SRC_WDRST   = 3;
  localparam int SRC_BUSERR  = 4;

  typedef logic [NSRC-1:0] src_vec_t;

  // reset value of each enable; bus source starts disabled
  localparam src_vec_t EN_RESET_VAL = 5'b01111;
  // bits software may change; vector fetch enable is fixed
  localparam src_vec_t EN_WR_MASK   = 5'b11110;
endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/nmi_flag_bank.sv
module nmi_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (rst)           f_q <= 1'b0;
      else if (set_i[i]) f_q <= 1'b1;   // a new event beats a clear
      else if (clr_i[i]) f_q <= 1'b0;
    end
    assign flags_o[i] = f_q;
  end
endmodule

// File: rtl/nmi_cfg_regs.sv
module nmi_cfg_regs #(
  parameter int         N       = 5,
  parameter logic [N-1:0] RST_VAL = '1,
  parameter logic [N-1:0] WR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst)       en_q <= RST_VAL;
    else if (wr_i) en_q <= (data_i & WR_MASK) | (en_q & ~WR_MASK);
  end

  assign en_o = en_q;
endmodule

// File: rtl/nmi_src_aggregator.sv
module nmi_src_aggregator
  import nmi_agg_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ENABLE_ADDR = 0,
  parameter int CLEAR_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vfetch_err_i,
  input  logic              clkfail_i,
  input  logic              pin_nmi_i,
  input  logic              peer_wdrst_i,
  input  logic              bus_int_stuck_i,
  input  logic              bus_rdy_stuck_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NSRC-1:0]   wr_data_i,
  output logic [NSRC-1:0]   flags_o,
  output logic [NSRC-1:0]   enables_o,
  output logic              nmi_o,
  output logic              peer_clkfail_o
);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(ENABLE_ADDR);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(CLEAR_ADDR);

  logic     pin_rise;
  src_vec_t set_vec, clr_vec, flags, en;
  logic     en_wr;
  logic     nmi_q, peer_q;

  nmi_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst(rst), .pin_i(pin_nmi_i), .rise_o(pin_rise)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[SRC_VFETCH]  = vfetch_err_i;
    set_vec[SRC_CLKFAIL] = clkfail_i;
    set_vec[SRC_PIN]     = pin_rise;
    set_vec[SRC_WDRST]   = peer_wdrst_i;
    set_vec[SRC_BUSERR]  = bus_int_stuck_i | bus_rdy_stuck_i;
  end

  assign clr_vec = (wr_en_i && wr_addr_i == A_CLR) ? wr_data_i : '0;
  assign en_wr   = wr_en_i && (wr_addr_i == A_EN);

  nmi_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec), .flags_o(flags)
  );

  nmi_cfg_regs #(.N(NSRC), .RST_VAL(EN_RESET_VAL), .WR_MASK(EN_WR_MASK)) u_cfg (
    .clk(clk), .rst(rst), .wr_i(en_wr), .data_i(wr_data_i), .en_o(en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q  <= 1'b0;
      peer_q <= 1'b0;
    end else begin
      nmi_q  <= |(flags & en);
      peer_q <= flags[SRC_CLKFAIL] & en[SRC_CLKFAIL];
    end
  end

  assign flags_o        = flags;
  assign enables_o      = en;
  assign nmi_o          = nmi_q;
  assign peer_clkfail_o = peer_q;
endmodule

// File: rtl/nmi_src_aggregator_chk.sv
module nmi_src_aggregator_chk
  import nmi_agg_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int ENABLE_ADDR = 0,
  parameter int CLEAR_ADDR  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              vfetch_err_i,
  input logic              clkfail_i,
  input logic              peer_wdrst_i,
  input logic              bus_int_stuck_i,
  input logic              bus_rdy_stuck_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [NSRC-1:0]   wr_data_i,
  input logic [NSRC-1:0]   flags_o,
  input logic [NSRC-1:0]   enables_o,
  input logic              nmi_o,
  input logic              peer_clkfail_o
);
  src_vec_t clr_c, keep_c, hard_c;
  logic     en_wr_c;

  always_comb begin
    clr_c   = (wr_en_i && wr_addr_i == ADDR_W'(CLEAR_ADDR)) ? wr_data_i : '0;
    en_wr_c = wr_en_i && wr_addr_i == ADDR_W'(ENABLE_ADDR);
    keep_c  = flags_o & ~clr_c;
    hard_c  = '0;
    hard_c[SRC_VFETCH]  = vfetch_err_i;
    hard_c[SRC_CLKFAIL] = clkfail_i;
    hard_c[SRC_WDRST]   = peer_wdrst_i;
    hard_c[SRC_BUSERR]  = bus_int_stuck_i | bus_rdy_stuck_i;
  end

  p_vfetch_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    enables_o[SRC_VFETCH] == 1'b1);

  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_o & $past(keep_c)) == $past(keep_c)));

  // covers R2, R4, R6 and R7: a live event always leaves its flag set
  p_event_sets_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_o & $past(hard_c)) == $past(hard_c)));

  p_nmi_follow_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (nmi_o == $past(|(flags_o & enables_o))));

  p_peer_follow_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (peer_clkfail_o == $past(flags_o[SRC_CLKFAIL] & enables_o[SRC_CLKFAIL])));

  p_en_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !en_wr_c |=> $stable(enables_o));
endmodule

bind nmi_src_aggregator nmi_src_aggregator_chk #(
  .ADDR_W(ADDR_W), .ENABLE_ADDR(ENABLE_ADDR), .CLEAR_ADDR(CLEAR_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .vfetch_err_i(vfetch_err_i), .clkfail_i(clkfail_i),
  .peer_wdrst_i(peer_wdrst_i), .bus_int_stuck_i(bus_int_stuck_i),
  .bus_rdy_stuck_i(bus_rdy_stuck_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .flags_o(flags_o), .enables_o(enables_o),
  .nmi_o(nmi_o), .peer_clkfail_o(peer_clkfail_o)
);

// File: tb/tb_nmi_src_aggregator.sv
module tb_nmi_src_aggregator;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vfetch = 0, clkfail = 0, pin = 0, wdrst = 0, bint = 0, brdy = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = '0;
  logic [4:0] wr_data = '0;
  logic [4:0] flags, ens;
  logic       nmi, peer;
  int         n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  nmi_src_aggregator dut (
    .clk(clk), .rst(rst), .vfetch_err_i(vfetch), .clkfail_i(clkfail),
    .pin_nmi_i(pin), .peer_wdrst_i(wdrst), .bus_int_stuck_i(bint),
    .bus_rdy_stuck_i(brdy), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .flags_o(flags), .enables_o(ens),
    .nmi_o(nmi), .peer_clkfail_o(peer)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 flags", flags, 0);
    chk("R1 enables", ens, 5'h0F);
    chk("R1 nmi", nmi, 0);
    chk("R1 peer", peer, 0);
  endtask

  task automatic t_sources;
    vfetch = 1; cyc(1); vfetch = 0;
    chk("R2 vfetch bit0", flags, 5'h01);
    cyc(1); chk("R9 nmi from vfetch", nmi, 1);
    wr(1, 5'h01); chk("R3 clear bit0", flags, 0);
    cyc(1); chk("R9 nmi drops", nmi, 0);

    clkfail = 1; cyc(1); clkfail = 0;
    chk("R2 clkfail bit1", flags, 5'h02);
    cyc(1); chk("R10 peer set", peer, 1); chk("R9 nmi clkfail", nmi, 1);
    wr(1, 5'h02); cyc(1); chk("R10 peer drops", peer, 0);

    wdrst = 1; cyc(1); wdrst = 0;
    chk("R2 wdrst bit3", flags, 5'h08);
    wr(1, 5'h08); cyc(1); chk("R9 nmi idle", nmi, 0);
  endtask

  task automatic t_sticky;
    wdrst = 1; cyc(1); wdrst = 0;
    wr(1, 5'h17); cyc(2);
    chk("R3 zero bit keeps flag", flags, 5'h08);
    wr(1, 5'h08);
    chk("R3 one bit clears", flags, 0);
  endtask

  task automatic t_set_wins;
    clkfail = 1; cyc(1);
    wr(1, 5'h02);
    chk("R4 event beats clear", flags, 5'h02);
    clkfail = 0; cyc(1);
    wr(1, 5'h02); chk("R4 clear after release", flags, 0);
  endtask

  task automatic t_enable;
    wr(0, 5'h00);
    chk("R5 bit0 fixed", ens, 5'h01);
    clkfail = 1; cyc(1); clkfail = 0; cyc(2);
    chk("R5 disabled no nmi", nmi, 0);
    chk("R10 disabled no peer", peer, 0);
    chk("R5 flag still latches", flags, 5'h02);
    vfetch = 1; cyc(1); vfetch = 0; cyc(1);
    chk("R5 vfetch undisableable", nmi, 1);
    wr(1, 5'h1F); wr(0, 5'h1F);
    chk("R5 all enabled", ens, 5'h1F);
    wr(0, 5'h0F); chk("R5 restore", ens, 5'h0F);
    cyc(1); chk("R9 quiet", nmi, 0);
  endtask

  task automatic t_bus;
    brdy = 1; cyc(1); brdy = 0;
    chk("R7 ready stuck sets bit4", flags, 5'h10);
    cyc(2); chk("R6 disabled no nmi", nmi, 0);
    wr(0, 5'h1F); cyc(1);
    chk("R6 enable later raises nmi", nmi, 1);
    wr(1, 5'h10); cyc(1); chk("R6 cleared", nmi, 0);
    bint = 1; cyc(1); bint = 0;
    chk("R7 int stuck sets bit4", flags, 5'h10);
    wr(1, 5'h10); wr(0, 5'h0F);
  endtask

  task automatic t_pin;
    pin = 1; cyc(2);
    chk("R8 not yet at 2 edges", flags, 0);
    cyc(1); chk("R8 set at 3 edges", flags, 5'h04);
    wr(1, 5'h04); cyc(4);
    chk("R8 held pin no reset", flags, 0);
    pin = 0; cyc(3); pin = 1; cyc(3);
    chk("R8 new rise sets", flags, 5'h04);
    pin = 0; wr(1, 5'h04);
  endtask

  task automatic t_hold;
    vfetch = 1; wdrst = 1; cyc(1); vfetch = 0; wdrst = 0;
    wr(1, 5'h01); cyc(1);
    chk("R9 stays with one flag", nmi, 1);
    wr(1, 5'h08); cyc(1);
    chk("R9 drops when all clear", nmi, 0);
  endtask

  task automatic t_other_addr;
    wdrst = 1; cyc(1); wdrst = 0;
    wr(2, 5'h1F); wr(3, 5'h1F); wr(2, 5'h00); wr(3, 5'h00);
    chk("R11 enables unchanged", ens, 5'h0F);
    chk("R11 flags unchanged", flags, 5'h08);
    wr(1, 5'h08);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    t_reset();
    t_sources();
    t_sticky();
    t_set_wins();
    t_enable();
    t_bus();
    t_pin();
    t_hold();
    t_other_addr();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule